// File: doc/BRIEF.md
# Double-Buffered Frame Fetch Sequencer

This block reads one display frame's worth of pixel words from memory and stores them in an internal 16-entry, 32-bit pixel FIFO. A downstream formatter takes words out through a valid/pop port. The host programs the block through a small register port. The frame geometry is held as a pixel count per line and a line count. A base address is double-buffered: the host writes the pending base at any time, and the block moves it into the live base only when the timing generator pulses `frame_start`.

Reads go out on a request/grant word interface. Responses return in order, with any latency. The block keeps the sum of FIFO occupancy and outstanding reads within the FIFO depth, so a response always has a free slot. A stop is graceful: clearing the streaming-enable bit halts new requests, and the run flag stays up until every outstanding read has landed and the FIFO has drained. The host can also flush the FIFO or soft-reset the whole block.

Top module: `frame_fetch_seq`

## Requirements
- R1: Register index is `host_addr[7:4]`: 0 control, 1 flush control, 2 geometry, 3 live base (read-only, writes ignored), 4 pending base. The alias `host_addr[3:2]` selects the write type: 0 overwrites, 1 ORs the data in (set), 2 clears the bits set in the data (clear), 3 does nothing. Reads return the register at any alias.
- R2: Geometry bits [15:0] hold the pixels per line and bits [31:16] the lines per frame. Control bit 8 selects 32-bit pixels, which gives one word per pixel. When it is 0, 16-bit pixels are packed two per word and a line takes ceil(pixels/2) words.
- R3: Within a frame, request addresses start at the live base and rise by 4 for each granted request. Responses enter the FIFO and leave `pix_data` in request order.
- R4: A `frame_start` pulse copies the pending base into the live base and restarts the fetch, but only while run (control bit 0) and streaming enable (control bit 17) are both 1. Otherwise it is ignored. Pending-base writes never change the live base between pulses.
- R5: A request is raised only while FIFO occupancy plus outstanding reads is below 16. With the consumer stalled, exactly 16 requests are granted.
- R6: Once control bit 17 is cleared, no new request is issued. Run stays 1 until no read is outstanding and the FIFO is empty, and then it clears by itself.
- R7: Writing 1 to bit 21 of the flush register, through the overwrite or set alias, empties the FIFO at that clock edge. The register reads back 0.
- R8: Writing 1 to control bit 31 returns every register, the FIFO and all counters to the reset state (all zero) at that edge.
- R9: A write that would raise run is refused (run stays 0) when pending-base bits [1:0] are not 00. The other control bits in the same write still take effect.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address (index and alias) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| frame_start | input | 1 | Frame boundary pulse from the timing generator |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Read byte address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| pix_valid | output | 1 | FIFO holds a word |
| pix_data | output | 32 | Oldest FIFO word |
| pix_pop | input | 1 | Consumer takes the oldest word |

## Verification
The bench stalls the consumer during a long line to test credit accounting. A design that counted only FIFO occupancy would over-issue past 16 grants and lose responses. It writes the pending base in the middle of a session and checks that the live base changes only at a running frame boundary. A design that forwarded the value at once would show the new base early. It clears streaming enable while the FIFO is full and checks that run holds until the consumer drains it. A premature clear shows as run reading 0 while words remain. Unaligned-base run refusal, flush and soft reset are checked at the ports, through readback and `pix_valid`.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

  localparam logic [3:0] REG_CTRL  = 4'd0;
  localparam logic [3:0] REG_FLUSH = 4'd1;
  localparam logic [3:0] REG_GEOM  = 4'd2;
  localparam logic [3:0] REG_LIVE  = 4'd3;
  localparam logic [3:0] REG_PEND  = 4'd4;

  localparam int unsigned BIT_RUN    = 0;
  localparam int unsigned BIT_PIX32  = 8;
  localparam int unsigned BIT_STREAM = 17;
  localparam int unsigned BIT_FLUSH  = 21;
  localparam int unsigned BIT_SRST   = 31;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } alias_op_e;

  typedef struct packed {
    logic run;
    logic stream;
    logic pix32;
  } ctrl_t;

  function automatic logic [31:0] apply_alias(input alias_op_e op,
                                              input logic [31:0] old_v,
                                              input logic [31:0] wd);
    case (op)
      OP_WRITE: apply_alias = wd;
      OP_SET:   apply_alias = old_v | wd;
      OP_CLR:   apply_alias = old_v & ~wd;
      default:  apply_alias = old_v;
    endcase
  endfunction

endpackage

// File: rtl/ffs_regs.sv
module ffs_regs
  import ffs_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [7:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          drain_done,
  input  logic [AW-1:0] live_base,
  output ctrl_t         ctrl,
  output logic [31:0]   geom,
  output logic [AW-1:0] pend_base,
  output logic          flush,
  output logic          soft_clr,
  output logic          ctrl_wr
);

  logic [3:0]    sel;
  alias_op_e     op;
  logic          op_ok;
  ctrl_t         ctrl_q, ctrl_n;
  logic [31:0]   geom_q, geom_n;
  logic [AW-1:0] pend_q, pend_n;
  logic [31:0]   ctrl_word, ctrl_new, flush_new;

  assign sel   = host_addr[7:4];
  assign op    = alias_op_e'(host_addr[3:2]);
  assign op_ok = host_we && (op != OP_NONE);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_RUN]    = ctrl_q.run;
    ctrl_word[BIT_STREAM] = ctrl_q.stream;
    ctrl_word[BIT_PIX32]  = ctrl_q.pix32;
  end

  assign ctrl_new  = apply_alias(op, ctrl_word, host_wdata);
  assign flush_new = apply_alias(op, 32'd0, host_wdata);
  assign ctrl_wr   = op_ok && (sel == REG_CTRL);
  assign soft_clr  = ctrl_wr && ctrl_new[BIT_SRST];
  assign flush     = op_ok && (sel == REG_FLUSH) && flush_new[BIT_FLUSH];

  always_comb begin
    ctrl_n = ctrl_q;
    geom_n = geom_q;
    pend_n = pend_q;
    if (drain_done) ctrl_n.run = 1'b0;
    if (ctrl_wr) begin
      ctrl_n.stream = ctrl_new[BIT_STREAM];
      ctrl_n.pix32  = ctrl_new[BIT_PIX32];
      ctrl_n.run    = ctrl_new[BIT_RUN] && (ctrl_q.run || (pend_q[1:0] == 2'b00));
    end
    if (op_ok && sel == REG_GEOM) geom_n = apply_alias(op, geom_q, host_wdata);
    if (op_ok && sel == REG_PEND) pend_n = apply_alias(op, pend_q, host_wdata);
    if (soft_clr) begin
      ctrl_n = '0;
      geom_n = '0;
      pend_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      geom_q <= '0;
      pend_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      geom_q <= geom_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL: host_rdata = ctrl_word;
      REG_GEOM: host_rdata = geom_q;
      REG_LIVE: host_rdata = 32'(live_base);
      REG_PEND: host_rdata = 32'(pend_q);
      default:  host_rdata = 32'd0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign geom      = geom_q;
  assign pend_base = pend_q;

endmodule

// File: rtl/ffs_fetch.sv
module ffs_fetch #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_clr,
  input  logic            run,
  input  logic            stream,
  input  logic            pix32,
  input  logic [31:0]     geom,
  input  logic [AW-1:0]   pend_base,
  input  logic            frame_start,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [CNTW-1:0] fifo_count,
  input  logic            fifo_empty,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [AW-1:0]   live_base,
  output logic [CNTW-1:0] pending,
  output logic            rsp_accept,
  output logic            drain_done
);

  localparam int unsigned LW = 16;

  logic [LW-1:0]   hpix, vlines, wpl;
  logic [LW:0]     half_up;
  logic            frame_go, fire, room, last_word, last_line;
  logic            active_q, active_n;
  logic [AW-1:0]   addr_q, addr_n, live_q, live_n;
  logic [LW-1:0]   word_q, word_n, line_q, line_n;
  logic [CNTW-1:0] pend_q, pend_n;

  assign hpix    = geom[LW-1:0];
  assign vlines  = geom[2*LW-1:LW];
  assign half_up = ({1'b0, hpix} + 1'b1) >> 1;
  assign wpl     = pix32 ? hpix : half_up[LW-1:0];

  assign frame_go   = frame_start && run && stream;
  assign room       = ({1'b0, fifo_count} + {1'b0, pend_q}) < (CNTW+1)'(DEPTH);
  assign mem_req    = active_q && run && stream && room;
  assign fire       = mem_req && mem_gnt;
  assign rsp_accept = mem_rvalid && (pend_q != '0);
  assign drain_done = run && !stream && (pend_q == '0) && fifo_empty;
  assign last_word  = (word_q == wpl - 1'b1);
  assign last_line  = (line_q == vlines - 1'b1);

  always_comb begin
    pend_n = pend_q;
    if (fire && !rsp_accept)      pend_n = pend_q + 1'b1;
    else if (!fire && rsp_accept) pend_n = pend_q - 1'b1;
    active_n = active_q;
    addr_n   = addr_q;
    live_n   = live_q;
    word_n   = word_q;
    line_n   = line_q;
    if (frame_go) begin
      live_n   = pend_base;
      addr_n   = pend_base;
      word_n   = '0;
      line_n   = '0;
      active_n = (wpl != '0) && (vlines != '0);
    end else if (fire) begin
      addr_n = addr_q + AW'(4);
      if (last_word) begin
        word_n = '0;
        if (last_line) active_n = 1'b0;
        else           line_n   = line_q + 1'b1;
      end else begin
        word_n = word_q + 1'b1;
      end
    end else if (!run) begin
      active_n = 1'b0;
    end
    if (soft_clr) begin
      pend_n   = '0;
      active_n = 1'b0;
      addr_n   = '0;
      live_n   = '0;
      word_n   = '0;
      line_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      active_q <= 1'b0;
      addr_q   <= '0;
      live_q   <= '0;
      word_q   <= '0;
      line_q   <= '0;
    end else begin
      pend_q   <= pend_n;
      active_q <= active_n;
      addr_q   <= addr_n;
      live_q   <= live_n;
      word_q   <= word_n;
      line_q   <= line_n;
    end
  end

  assign mem_addr  = addr_q;
  assign live_base = live_q;
  assign pending   = pend_q;

endmodule

// File: rtl/ffs_fifo.sv
module ffs_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  input  logic            rd,
  output logic [DW-1:0]   rdata,
  output logic            empty,
  output logic [CNTW-1:0] count
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]   mem [DEPTH];
  logic [PW-1:0]   wp_q, wp_n, rp_q, rp_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            do_wr, do_rd;

  assign do_wr = wr && !clr && (cnt_q != CNTW'(DEPTH));
  assign do_rd = rd && !clr && (cnt_q != '0);

  always_comb begin
    wp_n  = do_wr ? ((wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1) : wp_q;
    rp_n  = do_rd ? ((rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1) : rp_q;
    cnt_n = cnt_q;
    if (do_wr && !do_rd)      cnt_n = cnt_q + 1'b1;
    else if (!do_wr && do_rd) cnt_n = cnt_q - 1'b1;
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

endmodule

// File: rtl/frame_fetch_seq.sv
module frame_fetch_seq
  import ffs_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [7:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          frame_start,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          pix_valid,
  output logic [DW-1:0] pix_data,
  input  logic          pix_pop
);

  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  ctrl_t           ctrl;
  logic [31:0]     geom;
  logic [AW-1:0]   pend_base, live_base;
  logic            flush, soft_clr, ctrl_wr, drain_done, rsp_accept;
  logic [CNTW-1:0] fifo_count, pending;
  logic            fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ffs_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .drain_done (drain_done),
    .live_base  (live_base),
    .ctrl       (ctrl),
    .geom       (geom),
    .pend_base  (pend_base),
    .flush      (flush),
    .soft_clr   (soft_clr),
    .ctrl_wr    (ctrl_wr)
  );

  ffs_fetch #(.AW(AW), .DEPTH(DEPTH), .CNTW(CNTW)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .soft_clr    (soft_clr),
    .run         (ctrl.run),
    .stream      (ctrl.stream),
    .pix32       (ctrl.pix32),
    .geom        (geom),
    .pend_base   (pend_base),
    .frame_start (frame_start),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .fifo_count  (fifo_count),
    .fifo_empty  (fifo_empty),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .live_base   (live_base),
    .pending     (pending),
    .rsp_accept  (rsp_accept),
    .drain_done  (drain_done)
  );

  ffs_fifo #(.DW(DW), .DEPTH(DEPTH), .CNTW(CNTW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (flush || soft_clr),
    .wr    (rsp_accept),
    .wdata (mem_rdata),
    .rd    (pix_pop),
    .rdata (pix_data),
    .empty (fifo_empty),
    .count (fifo_count)
  );

  assign pix_valid = !fifo_empty;

endmodule

// File: rtl/ffs_checker.sv
module ffs_checker #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNTW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            stream,
  input logic [AW-1:0]   pend_base,
  input logic [AW-1:0]   live_base,
  input logic            frame_start,
  input logic            mem_req,
  input logic            mem_gnt,
  input logic [AW-1:0]   mem_addr,
  input logic [CNTW-1:0] fifo_count,
  input logic [CNTW-1:0] pending,
  input logic            fifo_empty,
  input logic            fifo_wr,
  input logic            soft_clr,
  input logic            ctrl_wr
);

  logic go;
  assign go = frame_start && run && stream;

  assert_credit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fifo_count} + {1'b0, pending}) <= (CNTW+1)'(DEPTH));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_count != CNTW'(DEPTH)));

  assert_run_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(pend_base[1:0]) == 2'b00));

  assert_stop_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run) && !$past(ctrl_wr) && !$past(soft_clr))
      |-> $past(fifo_empty && (pending == '0) && !stream));

  assert_live_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !soft_clr) |=> $stable(live_base));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !go && !soft_clr) |=> (mem_addr == $past(mem_addr) + AW'(4)));

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!run && !stream && fifo_empty && (pending == '0)
                  && (live_base == '0) && (pend_base == '0)));

endmodule

bind frame_fetch_seq ffs_checker #(.AW(AW), .DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .run         (ctrl.run),
  .stream      (ctrl.stream),
  .pend_base   (pend_base),
  .live_base   (live_base),
  .frame_start (frame_start),
  .mem_req     (mem_req),
  .mem_gnt     (mem_gnt),
  .mem_addr    (mem_addr),
  .fifo_count  (fifo_count),
  .pending     (pending),
  .fifo_empty  (fifo_empty),
  .fifo_wr     (rsp_accept),
  .soft_clr    (soft_clr),
  .ctrl_wr     (ctrl_wr)
);

// File: tb/frame_fetch_seq_tb.sv
`timescale 1ns/1ps
module frame_fetch_seq_tb;

  localparam logic [31:0] PAT = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = 8'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic        frame_start = 1'b0;
  logic        mem_req, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        pix_valid, pix_pop;
  logic [31:0] pix_data;

  logic        sink_en = 1'b0;
  logic        stall_en = 1'b0;
  logic        clr_cnt = 1'b0;
  logic        gnt_tog = 1'b0;
  logic [2:0]  p_v = 3'b000;
  logic [31:0] p_d0 = 0, p_d1 = 0, p_d2 = 0;
  logic [31:0] cap [64];
  int          cap_n = 0;
  int          gcnt = 0;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  frame_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .frame_start(frame_start),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_pop(pix_pop)
  );

  assign mem_gnt    = !stall_en || gnt_tog;
  assign mem_rvalid = p_v[2];
  assign mem_rdata  = p_d2;
  assign pix_pop    = sink_en && pix_valid;

  always @(posedge clk) begin
    gnt_tog <= ~gnt_tog;
    p_v  <= {p_v[1:0], mem_req && mem_gnt};
    p_d0 <= mem_addr ^ PAT;
    p_d1 <= p_d0;
    p_d2 <= p_d1;
    if (clr_cnt) begin
      cap_n <= 0;
      gcnt  <= 0;
    end else begin
      if (mem_req && mem_gnt) gcnt <= gcnt + 1;
      if (pix_pop && cap_n < 64) begin
        cap[cap_n] <= pix_data;
        cap_n <= cap_n + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic clear_counts();
    @(negedge clk); clr_cnt = 1'b1;
    @(negedge clk); clr_cnt = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_stream(input string req, input logic [31:0] base, input int n);
    check(req, cap_n, n);
    for (int i = 0; i < n && i < 64; i++)
      check(req, cap[i], (base + 32'(4 * i)) ^ PAT);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R8 reset ctrl", v, 0);
    rd(8'h20, v); check("R8 reset geom", v, 0);
    rd(8'h30, v); check("R8 reset live", v, 0);
    rd(8'h40, v); check("R8 reset pend", v, 0);
    check("R5 reset req", mem_req, 0);
    check("R8 reset pix_valid", pix_valid, 0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(8'h40, 32'h0000_1000);
    wr(8'h44, 32'h0000_00F0);
    rd(8'h40, v); check("R1 set alias", v, 32'h0000_10F0);
    wr(8'h48, 32'h0000_1000);
    rd(8'h40, v); check("R1 clear alias", v, 32'h0000_00F0);
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h40, v); check("R1 no-op alias", v, 32'h0000_00F0);
    wr(8'h30, 32'h1234_5678);
    rd(8'h30, v); check("R1 live read-only", v, 0);
    wr(8'h20, 32'h0002_0000);
    wr(8'h24, 32'h0000_0003);
    rd(8'h28, v); check("R1 geom via alias read", v, 32'h0002_0003);
  endtask

  task automatic t_run_guard();
    logic [31:0] v;
    wr(8'h40, 32'h0000_00F2);
    wr(8'h00, 32'h0002_0101);
    rd(8'h00, v); check("R9 unaligned run refused", v, 32'h0002_0100);
    wr(8'h40, 32'h0000_1000);
    wr(8'h04, 32'h0000_0001);
    rd(8'h00, v); check("R9 aligned run accepted", v, 32'h0002_0101);
  endtask

  task automatic t_frame32();
    logic [31:0] v;
    clear_counts();
    sink_en = 1'b1;
    pulse_frame();
    wait_cyc(50);
    check_stream("R3 R2 32-bit frame", 32'h0000_1000, 6);
    rd(8'h30, v); check("R4 live base after start", v, 32'h0000_1000);
  endtask

  task automatic t_frame16_swap();
    logic [31:0] v;
    clear_counts();
    stall_en = 1'b1;
    wr(8'h40, 32'h0000_2000);
    wr(8'h08, 32'h0000_0100);
    wr(8'h20, 32'h0002_0005);
    rd(8'h30, v); check("R4 live unchanged before boundary", v, 32'h0000_1000);
    pulse_frame();
    wait_cyc(60);
    check_stream("R2 16-bit packed frame", 32'h0000_2000, 6);
    rd(8'h30, v); check("R4 live swapped", v, 32'h0000_2000);
    stall_en = 1'b0;
  endtask

  task automatic t_credit();
    clear_counts();
    sink_en = 1'b0;
    wr(8'h04, 32'h0000_0100);
    wr(8'h20, 32'h0001_0028);
    wr(8'h40, 32'h0000_3000);
    pulse_frame();
    wait_cyc(60);
    check("R5 grants capped at depth", gcnt, 16);
    check("R5 nothing consumed", cap_n, 0);
    sink_en = 1'b1;
    wait_cyc(200);
    check_stream("R5 R3 long line", 32'h0000_3000, 40);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    clear_counts();
    sink_en = 1'b0;
    wr(8'h40, 32'h0000_4000);
    pulse_frame();
    wait_cyc(60);
    wr(8'h08, 32'h0002_0000);
    rd(8'h00, v); check("R6 run held while full", v[0], 1'b1);
    wait_cyc(20);
    rd(8'h00, v); check("R6 run still held", v[0], 1'b1);
    check("R6 no request after stop", gcnt, 16);
    sink_en = 1'b1;
    wait_cyc(40);
    rd(8'h00, v); check("R6 run self-clears after drain", v[0], 1'b0);
    check_stream("R6 drained words", 32'h0000_4000, 16);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    clear_counts();
    sink_en = 1'b0;
    wr(8'h20, 32'h0001_0004);
    wr(8'h04, 32'h0002_0001);
    pulse_frame();
    wait_cyc(30);
    check("R7 fifo filled", pix_valid, 1'b1);
    wr(8'h14, 32'h0020_0000);
    check("R7 flush empties fifo", pix_valid, 1'b0);
    rd(8'h10, v); check("R7 flush reads zero", v, 0);
    sink_en = 1'b1;
    wait_cyc(10);
    check("R7 no word after flush", cap_n, 0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wr(8'h04, 32'h8000_0000);
    rd(8'h00, v); check("R8 soft reset ctrl", v, 0);
    rd(8'h20, v); check("R8 soft reset geom", v, 0);
    rd(8'h40, v); check("R8 soft reset pend", v, 0);
    rd(8'h30, v); check("R8 soft reset live", v, 0);
    check("R8 soft reset fifo", pix_valid, 0);
    clear_counts();
    pulse_frame();
    wait_cyc(20);
    check("R4 frame_start ignored when stopped", gcnt, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_alias();
    t_run_guard();
    t_frame32();
    t_frame16_swap();
    t_credit();
    t_stop();
    t_flush();
    t_soft_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule